// File: doc/BRIEF.md
# Two-Channel Gate Enable Sequencer

This block decides, cycle by cycle, whether each of two output channels may drive its pair of pass-transistor gates. Every channel has an on request that has already been thresholded to a logic level. A channel becomes qualified only after its request has been held high for a programmable turn-on delay. It loses qualification only after the request has stayed low for a programmable deglitch time, so brief dips are ignored.

A shared fast-off input pulls all gate enables low at once, through combinational gating with no register in the path. When fast-off releases, a timed quiet period must pass before either channel may turn back on. A turn-on delay that a fast-off interrupted starts again from zero once that quiet period ends. A supply-good status and a per-channel permit from an external fault manager also gate the outputs.

Each time a channel's qualification rises, the block sends a one-cycle clear pulse to the fault manager. A request taken low and then high therefore releases a latched fault. All timing counts only cycles on which the `tick` strobe is high.

Top module: `chan_gate_sequencer`

## Requirements
- R1: With `tick` held high, a channel's gate enables rise on the (2+ON_DLY)th rising clock edge after its on request goes high; the 2 covers the input synchronizer.
- R2: A qualified channel turns off on the (2+OFF_DGL)th rising edge after its request goes low. A low dip lasting at most OFF_DGL-1 clock cycles leaves the gates high throughout.
- R3: While `fast_off` is high, every bit of `gate_en` is 0 in the same cycle, whatever the requests are.
- R4: After `fast_off` falls, all gates stay 0 until the (2+FO_REC)th rising edge. From that edge on, an already qualified channel drives its gates high again without a new turn-on delay.
- R5: While `uv_ok` is low, every gate is 0. When `uv_ok` returns high, a qualified channel's gates return in the same cycle.
- R6: Channel c drives `gate_en[c*GPC +: GPC]`, with bits [1:0] for channel 0 and [3:2] for channel 1 at the default GPC=2. All bits of a channel are equal. Each channel follows only its own request and its own `fault_permit` bit, and a low permit forces that channel's gates to 0.
- R7: `fault_clr[c]` is high for exactly one cycle, registered on the same edge as channel c's qualification rise. It pulses even when `fault_permit[c]` is low.
- R8: If `fast_off` pulses during a turn-on delay, the delay restarts after recovery. The gates rise on the (2+FO_REC+ON_DLY)th edge after `fast_off` falls.
- R9: The delay counters advance only on cycles with `tick` high. With `tick` low, a pending turn-on never completes.
- R10: While `rst_n` is low, all gate enables and all clear pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe; delays count these cycles |
| on_req | input | NCH | Per-channel on request, asynchronous |
| fast_off | input | 1 | Global fast turn-off, asynchronous, active high |
| uv_ok | input | 1 | Input supply above its undervoltage level |
| fault_permit | input | NCH | Per-channel permit from the fault manager |
| gate_en | output | NCH*GPC | Gate enables, GPC per channel |
| fault_clr | output | NCH | One-cycle fault-latch clear per channel |

## Verification
The hardest situation to reach from the ports is a fast-off that lands partway through a turn-on delay. In that case the partial count must be thrown away rather than resumed after recovery. The stimulus raises a request, asserts `fast_off` three edges later, holds it for two edges and releases it. It then samples the gates one edge before and at the predicted edge, 2+FO_REC+ON_DLY edges after release. A resumed count would make the gates rise too early and fail the first sample. The deglitch boundary is also probed with a dip one cycle shorter than the off filter.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    localparam int unsigned TMR_W = 16;

    typedef struct packed {
        logic             qual;
        logic             clr;
        logic [TMR_W-1:0] cnt;
    } qual_state_t;

    typedef struct packed {
        logic             busy;
        logic [TMR_W-1:0] cnt;
    } rec_state_t;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;
endmodule

// File: rtl/fo_capture.sv
module fo_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_off,
    output logic fo_s
);
    logic meta_q, s2_q;

    // Asynchronous set so even a sub-cycle pulse opens the recovery window
    always_ff @(posedge clk or posedge fast_off or negedge rst_n) begin
        if (!rst_n)        meta_q <= 1'b0;
        else if (fast_off) meta_q <= 1'b1;
        else               meta_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= 1'b0;
        else        s2_q <= meta_q;
    end

    assign fo_s = s2_q;
endmodule

// File: rtl/fo_recovery.sv
module fo_recovery
    import chan_seq_pkg::*;
#(
    parameter int unsigned FO_REC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fo_s,
    output logic active
);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(FO_REC - 1);

    rec_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fo_s) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy && tick) begin
            if (st_q.cnt >= LAST) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = fo_s | st_q.busy;
endmodule

// File: rtl/chan_qualifier.sv
module chan_qualifier
    import chan_seq_pkg::*;
#(
    parameter int unsigned ON_DLY  = 2000,
    parameter int unsigned OFF_DGL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req_s,
    input  logic hold,
    output logic qual,
    output logic clr_pulse
);
    localparam logic [TMR_W-1:0] ON_LAST  = TMR_W'(ON_DLY - 1);
    localparam logic [TMR_W-1:0] OFF_LAST = TMR_W'(OFF_DGL - 1);

    qual_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.clr = 1'b0;
        if (!st_q.qual) begin
            // pending turn-on is discarded on a request drop or any hold
            if (!req_s || hold) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt >= ON_LAST) begin
                    st_d.qual = 1'b1;
                    st_d.clr  = 1'b1;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            if (req_s) begin
                st_d.cnt = '0;
            end else if (tick) begin
                if (st_q.cnt >= OFF_LAST) begin
                    st_d.qual = 1'b0;
                    st_d.cnt  = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual      = st_q.qual;
    assign clr_pulse = st_q.clr;
endmodule

// File: rtl/chan_gate_sequencer.sv
module chan_gate_sequencer #(
    parameter int unsigned NCH     = 2,
    parameter int unsigned GPC     = 2,
    parameter int unsigned ON_DLY  = 2000,
    parameter int unsigned OFF_DGL = 10,
    parameter int unsigned FO_REC  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [NCH-1:0]       on_req,
    input  logic                 fast_off,
    input  logic                 uv_ok,
    input  logic [NCH-1:0]       fault_permit,
    output logic [NCH*GPC-1:0]   gate_en,
    output logic [NCH-1:0]       fault_clr
);
    logic [NCH-1:0] req_s;
    logic [NCH-1:0] qual;
    logic           fo_s;
    logic           rec_active;
    logic           hold;

    req_sync #(.W(NCH)) req_sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (on_req),
        .dout (req_s)
    );

    fo_capture fo_capture_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .fast_off(fast_off),
        .fo_s    (fo_s)
    );

    fo_recovery #(.FO_REC(FO_REC)) fo_recovery_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .fo_s  (fo_s),
        .active(rec_active)
    );

    assign hold = fast_off | rec_active | ~uv_ok;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_qualifier #(.ON_DLY(ON_DLY), .OFF_DGL(OFF_DGL)) qual_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .req_s    (req_s[c]),
            .hold     (hold),
            .qual     (qual[c]),
            .clr_pulse(fault_clr[c])
        );
        // raw fast_off gates the outputs with no register in the path
        assign gate_en[c*GPC +: GPC] =
            {GPC{qual[c] & ~fast_off & ~rec_active & uv_ok & fault_permit[c]}};
    end
endmodule

// File: rtl/chan_gate_sequencer_chk.sv
module chan_gate_sequencer_chk #(
    parameter int unsigned NCH = 2,
    parameter int unsigned GPC = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               fast_off,
    input logic               uv_ok,
    input logic [NCH-1:0]     fault_permit,
    input logic [NCH*GPC-1:0] gate_en,
    input logic [NCH-1:0]     fault_clr
);
    // R3
    fo_gates_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_off |-> (gate_en == '0));

    // R4
    fo_release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fast_off) |=> (gate_en == '0));

    // R5
    uv_gates_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uv_ok |-> (gate_en == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6
        permit_gates_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fault_permit[c] |-> (gate_en[c*GPC +: GPC] == '0));

        // R6
        pair_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(gate_en[c*GPC +: GPC]) == 0) ||
            ($countones(gate_en[c*GPC +: GPC]) == GPC));

        // R7
        clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fault_clr[c] |=> !fault_clr[c]);
    end
endmodule

bind chan_gate_sequencer chan_gate_sequencer_chk #(.NCH(NCH), .GPC(GPC)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_off    (fast_off),
    .uv_ok       (uv_ok),
    .fault_permit(fault_permit),
    .gate_en     (gate_en),
    .fault_clr   (fault_clr)
);

// File: tb/chan_gate_sequencer_tb_top.sv
module chan_gate_sequencer_tb_top;
    localparam int NCH = 2, GPC = 2, ON_DLY = 4, OFF_DGL = 3, FO_REC = 5;

    logic clk = 0, rst_n = 0, tick = 1, fast_off = 0, uv_ok = 1;
    logic [1:0] on_req = 2'b00, fault_permit = 2'b11;
    logic [3:0] gate_en;
    logic [1:0] fault_clr;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    chan_gate_sequencer #(.NCH(NCH), .GPC(GPC), .ON_DLY(ON_DLY),
                          .OFF_DGL(OFF_DGL), .FO_REC(FO_REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .on_req(on_req),
        .fast_off(fast_off), .uv_ok(uv_ok), .fault_permit(fault_permit),
        .gate_en(gate_en), .fault_clr(fault_clr));

    // vector: {req[1:0], permit[1:0], uv, expected gate_en[3:0]}
    localparam logic [8:0] VEC [8] = '{
        {2'b11, 2'b11, 1'b1, 4'b1111},
        {2'b01, 2'b11, 1'b1, 4'b0011},
        {2'b10, 2'b11, 1'b1, 4'b1100},
        {2'b00, 2'b11, 1'b1, 4'b0000},
        {2'b11, 2'b01, 1'b1, 4'b0011},
        {2'b11, 2'b10, 1'b1, 4'b1100},
        {2'b11, 2'b11, 1'b0, 4'b0000},
        {2'b11, 2'b11, 1'b1, 4'b1111}
    };

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R10 reset state
        edges(3);
        chk("R10 gates in reset", 32'(gate_en), 0);
        chk("R10 clr in reset", 32'(fault_clr), 0);
        rst_n = 1;
        edges(2);

        // R6 table of steady-state patterns
        for (int i = 0; i < 8; i++) begin
            on_req       = VEC[i][8:7];
            fault_permit = VEC[i][6:5];
            uv_ok        = VEC[i][4];
            edges(14);
            chk($sformatf("R6 vector %0d", i), 32'(gate_en), 32'(VEC[i][3:0]));
        end
        on_req = 2'b00; fault_permit = 2'b11; uv_ok = 1;
        edges(10);

        // R1 turn-on delay, R7 clear pulse
        on_req = 2'b01;
        edges(5);
        chk("R1 before delay", 32'(gate_en), 0);
        edges(1);
        chk("R1 at delay", 32'(gate_en), 32'h3);
        chk("R7 clear pulse", 32'(fault_clr), 1);
        edges(1);
        chk("R7 clear single", 32'(fault_clr), 0);

        // R2 short dip ignored
        on_req = 2'b00;
        edges(2);
        on_req = 2'b01;
        for (int k = 0; k < 8; k++) begin
            chk("R2 dip ignored", 32'(gate_en), 32'h3);
            edges(1);
        end

        // R2 sustained low turns off
        on_req = 2'b00;
        edges(4);
        chk("R2 before deglitch", 32'(gate_en), 32'h3);
        edges(1);
        chk("R2 after deglitch", 32'(gate_en), 0);

        // R7 clear pulse with permit low
        fault_permit = 2'b10;
        on_req = 2'b01;
        edges(6);
        chk("R7 clr with permit low", 32'(fault_clr), 1);
        chk("R6 permit low gates", 32'(gate_en), 0);
        edges(1);
        fault_permit = 2'b11;
        #1;
        chk("R6 permit restored", 32'(gate_en), 32'h3);

        // R3 / R4 fast-off and recovery
        on_req = 2'b11;
        edges(8);
        chk("R6 both on", 32'(gate_en), 32'hF);
        fast_off = 1;
        #1;
        chk("R3 immediate off", 32'(gate_en), 0);
        edges(3);
        chk("R3 held off", 32'(gate_en), 0);
        fast_off = 0;
        edges(6);
        chk("R4 still quiet", 32'(gate_en), 0);
        edges(1);
        chk("R4 recovered", 32'(gate_en), 32'hF);

        // R8 fast-off during turn-on delay
        on_req = 2'b00;
        edges(8);
        on_req = 2'b01;
        edges(3);
        fast_off = 1;
        edges(2);
        fast_off = 0;
        edges(10);
        chk("R8 before restarted delay", 32'(gate_en), 0);
        edges(1);
        chk("R8 after restarted delay", 32'(gate_en), 32'h3);

        // R5 undervoltage
        uv_ok = 0;
        #1;
        chk("R5 uv off", 32'(gate_en), 0);
        edges(3);
        chk("R5 uv held", 32'(gate_en), 0);
        uv_ok = 1;
        #1;
        chk("R5 uv restore", 32'(gate_en), 32'h3);

        // R9 tick gating
        on_req = 2'b00;
        edges(8);
        tick = 0;
        on_req = 2'b01;
        edges(20);
        chk("R9 no tick no turn-on", 32'(gate_en), 0);
        tick = 1;
        edges(3);
        chk("R9 before ticks done", 32'(gate_en), 0);
        edges(1);
        chk("R9 after ticks", 32'(gate_en), 32'h3);

        finish_run();
    end
endmodule